// File: doc/BRIEF.md
# Saturating Arithmetic Shift Unit

This execution unit serves one custom register-register instruction. It takes a signed source operand, shifts it right arithmetically by the amount held in a second source register, and clamps the shifted value into a signed range. The width of that range, the clamp width, is a 7-bit field carried in the instruction word. The unit decodes its own opcode and function field. When the instruction does not match, or when any argument is out of range, the register-file write is dropped. No trap is raised in that case.

The datapath is combinational from the instruction and operands up to one output register. A result, its destination index and its write-enable therefore appear one clock after the strobed inputs. Register-file access, hazards and exceptions belong to the surrounding pipeline.

Top module: `sat_shift_unit`

## Requirements
- R1: An instruction is accepted only when its bits [6:0] equal 0101011 and its bits [14:12] equal 000. The clamp width N is read from bits [31:25] and the destination index from bits [11:7].
- R2: The first operand, `src_a`, is shifted right arithmetically, with sign copies filling from the top, by the unsigned value of `src_b`. The shift is applied before any clamping.
- R3: For clamp width N, the upper limit is 2^(N-1)-1 and the lower limit is -2^(N-1).
- R4: A shifted value above the upper limit yields the upper limit. A shifted value below the lower limit yields the lower limit. Any other shifted value is passed on unchanged.
- R5: A write happens only when all of the following hold: the destination index is not 0, N lies between 1 and 32 inclusive, and `src_b`, taken as a 32-bit unsigned number, is below 32.
- R6: When no write happens, `out_we`, `out_rd` and `out_data` are all zero.
- R7: With N equal to 32, the limits span the full 32-bit signed range, so the output equals the shifted operand with no wrap.
- R8: The outputs take the value computed from the inputs at a rising clock edge, and hold it until the next edge. While reset is active, all outputs are zero.
- R9: With `in_valid` low, no write happens, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Operand to be shifted and clamped |
| src_b | input | 32 | Shift amount, unsigned |
| out_rd | output | 5 | Destination register index, zero when no write |
| out_data | output | 32 | Clamped result, zero when no write |
| out_we | output | 1 | Register-file write-enable |

## Verification
The hardest case to reach is the one where the limit itself sits at the edge of the word. That is N equal to 32 with the shift at 0 or 31, where the most negative operand must pass through untouched rather than wrap. Other hard cases are a shift amount of 32 or more, which must kill the write even though its low five bits look legal, and N of 33, which must do the same. The stimulus sweeps every N from 0 to 34 against every shift amount from 0 to 33, plus one very large shift. Each combination is applied to a fixed set of extreme operands and pseudo-random operands, so every one of these corners is crossed deterministically.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;
    localparam logic [6:0] SAS_OPCODE = 7'b0101011;
    localparam logic [2:0] SAS_FUNCT3 = 3'b000;
    localparam int         RD_W       = 5;
    localparam int         NFIELD_W   = 7;

    typedef struct packed {
        logic                legal;
        logic [RD_W-1:0]     rd;
        logic [NFIELD_W-1:0] width;
    } sas_dec_t;
endpackage

// File: rtl/sas_decode.sv
module sas_decode
    import sat_shift_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src_b,
    output sas_dec_t        dec
);
    logic match;
    logic width_ok;
    logic shift_ok;

    always_comb begin
        dec.rd    = instr[11:7];
        dec.width = instr[31:25];
        match     = (instr[6:0] == SAS_OPCODE) && (instr[14:12] == SAS_FUNCT3);
        width_ok  = (dec.width != '0) && (dec.width <= NFIELD_W'(XLEN));
        shift_ok  = (src_b < XLEN'(XLEN));
        dec.legal = in_valid && match && (dec.rd != '0) && width_ok && shift_ok;
    end
endmodule

// File: rtl/sas_shift.sv
module sas_shift #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] operand,
    input  logic [SHW-1:0]  amount,
    output logic [XLEN-1:0] shifted
);
    always_comb begin
        shifted = XLEN'($signed(operand) >>> amount);
    end
endmodule

// File: rtl/sas_clamp.sv
module sas_clamp
    import sat_shift_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]     value,
    input  logic [NFIELD_W-1:0] width,
    output logic [XLEN-1:0]     clamped
);
    logic [NFIELD_W-1:0] width_m1;
    logic [SHW-1:0]      pos;
    logic signed [XLEN:0] unit_w;
    logic signed [XLEN:0] lim_hi;
    logic signed [XLEN:0] lim_lo;
    logic signed [XLEN:0] wide;

    always_comb begin
        width_m1 = width - NFIELD_W'(1);
        pos      = width_m1[SHW-1:0];
        unit_w   = (XLEN+1)'(1) << pos;
        lim_hi   = unit_w - (XLEN+1)'(1);
        lim_lo   = -unit_w;
        wide     = {value[XLEN-1], value};
        if (wide > lim_hi)      clamped = lim_hi[XLEN-1:0];
        else if (wide < lim_lo) clamped = lim_lo[XLEN-1:0];
        else                    clamped = value;
    end
endmodule

// File: rtl/sat_shift_unit.sv
module sat_shift_unit
    import sat_shift_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [RD_W-1:0] out_rd,
    output logic [XLEN-1:0] out_data,
    output logic            out_we
);
    typedef struct packed {
        logic            we;
        logic [RD_W-1:0] rd;
        logic [XLEN-1:0] data;
    } sas_out_t;

    sas_dec_t        dec;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] clamped;
    sas_out_t        res_d;
    sas_out_t        res_q;

    sas_decode #(.XLEN(XLEN)) u_dec (
        .in_valid (in_valid),
        .instr    (instr),
        .src_b    (src_b),
        .dec      (dec)
    );

    sas_shift #(.XLEN(XLEN)) u_shift (
        .operand (src_a),
        .amount  (src_b[SHW-1:0]),
        .shifted (shifted)
    );

    sas_clamp #(.XLEN(XLEN)) u_clamp (
        .value   (shifted),
        .width   (dec.width),
        .clamped (clamped)
    );

    always_comb begin
        res_d = '0;
        if (dec.legal) begin
            res_d.we   = 1'b1;
            res_d.rd   = dec.rd;
            res_d.data = clamped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_we   = res_q.we;
    assign out_rd   = res_q.rd;
    assign out_data = res_q.data;
endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [4:0]      out_rd,
    input logic [XLEN-1:0] out_data,
    input logic            out_we
);
    logic [6:0]      n_q;
    logic [XLEN-1:0] a_q;
    logic [XLEN-1:0] b_q;
    longint          hi_c;
    longint          lo_c;

    always_ff @(posedge clk) begin
        n_q <= instr[31:25];
        a_q <= src_a;
        b_q <= src_b;
    end

    always_comb begin
        if (n_q == 7'd0 || n_q > 7'd63) begin
            hi_c = 0;
            lo_c = 0;
        end else begin
            hi_c = (longint'(1) << (n_q - 7'd1)) - 1;
            lo_c = -(longint'(1) << (n_q - 7'd1));
        end
    end

    p_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> ($past(instr[6:0]) == 7'b0101011 && $past(instr[14:12]) == 3'b000
                    && $past(instr[11:7]) == out_rd));

    p_limits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (longint'($signed(out_data)) <= hi_c && longint'($signed(out_data)) >= lo_c));

    p_legal_args_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (out_rd != 5'd0 && n_q >= 7'd1 && n_q <= 7'(XLEN) && b_q < XLEN'(XLEN)));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_we |-> (out_rd == 5'd0 && out_data == '0));

    p_full_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && n_q == 7'(XLEN)) |-> (out_data == XLEN'($signed(a_q) >>> b_q)));

    p_valid_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> $past(in_valid));
endmodule

bind sat_shift_unit sas_checker #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .instr    (instr),
    .src_a    (src_a),
    .src_b    (src_b),
    .out_rd   (out_rd),
    .out_data (out_data),
    .out_we   (out_we)
);

// File: tb/sim_sat_shift_unit.sv
`timescale 1ns/1ps
module sim_sat_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [4:0]  out_rd;
    logic [31:0] out_data;
    logic        out_we;

    int checks = 0;
    int fails  = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #4 clk = ~clk;

    sat_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .out_rd(out_rd), .out_data(out_data), .out_we(out_we)
    );

    function automatic logic [31:0] mk_instr(int n, int rd, logic [6:0] opc, logic [2:0] f3);
        return {7'(n), 5'd3, 5'd2, f3, 5'(rd), opc};
    endfunction

    function automatic logic [31:0] ref_val(logic [31:0] a, logic [31:0] b, int n);
        longint v, hi, lo;
        v  = longint'($signed(a));
        v  = v >>> b[4:0];
        hi = (longint'(1) << (n - 1)) - 1;
        lo = -(longint'(1) << (n - 1));
        if (v > hi) v = hi;
        else if (v < lo) v = lo;
        return v[31:0];
    endfunction

    task automatic check(string tag, logic e_we, logic [4:0] e_rd, logic [31:0] e_data);
        checks++;
        if (out_we !== e_we || out_rd !== e_rd || out_data !== e_data) begin
            fails++;
            $display("FAIL %s: got we=%0b rd=%0d data=%h, expected we=%0b rd=%0d data=%h",
                     tag, out_we, out_rd, out_data, e_we, e_rd, e_data);
        end
    endtask

    // Drive at negedge, the result registers at the next posedge, sample at the negedge after.
    task automatic apply(logic v, logic [31:0] ins, logic [31:0] a, logic [31:0] b,
                         string tag, logic e_we, logic [4:0] e_rd, logic [31:0] e_data);
        in_valid = v; instr = ins; src_a = a; src_b = b;
        @(posedge clk);
        @(negedge clk);
        check(tag, e_we, e_rd, e_data);
    endtask

    task automatic run_case(int n, logic [31:0] b, logic [31:0] a, int rd);
        logic        legal;
        logic [31:0] e;
        string       tag;
        legal = (rd != 0) && (n >= 1) && (n <= 32) && (b < 32);
        e = legal ? ref_val(a, b, n) : 32'd0;
        if (!legal) tag = (rd == 0) ? "R5" : "R6";
        else if (n == 32) tag = "R7";
        else if (e != ref_val(a, b, 33)) tag = "R4";
        else tag = "R2";
        apply(1'b1, mk_instr(n, rd, 7'b0101011, 3'b000), a, b, tag,
              legal, legal ? 5'(rd) : 5'd0, e);
    endtask

    function automatic logic [31:0] pick_op(int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h1234_5678;
            6: return 32'hFEDC_BA98;
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] b;
        logic [31:0] a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check("R8", 1'b0, 5'd0, 32'd0);
        rst_n = 1'b1;

        // Sweep clamp width, shift amount and operand
        for (int n = 0; n <= 34; n++) begin
            for (int s = 0; s <= 34; s++) begin
                b = (s == 34) ? 32'h8000_0003 : 32'(s);
                for (int k = 0; k < 10; k++) begin
                    if (k < 7) a = pick_op(k);
                    else begin
                        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                        a = lfsr;
                    end
                    run_case(n, b, a, ((n + s + k) % 31) + 1);
                end
            end
        end

        // R5: destination zero never writes
        for (int n = 1; n <= 32; n += 7) run_case(n, 32'd3, 32'h8000_0000, 0);

        // R1: wrong opcode or wrong funct3 is not accepted
        apply(1'b1, mk_instr(8, 5, 7'b0101010, 3'b000), 32'h7FFF_FFFF, 32'd0, "R1", 1'b0, 5'd0, 32'd0);
        apply(1'b1, mk_instr(8, 5, 7'b0101011, 3'b001), 32'h7FFF_FFFF, 32'd0, "R1", 1'b0, 5'd0, 32'd0);
        apply(1'b1, mk_instr(8, 5, 7'b1101011, 3'b000), 32'h7FFF_FFFF, 32'd0, "R1", 1'b0, 5'd0, 32'd0);
        apply(1'b1, mk_instr(8, 5, 7'b0101011, 3'b100), 32'h7FFF_FFFF, 32'd0, "R1", 1'b0, 5'd0, 32'd0);
        // R1: accepted encoding, field positions honoured
        apply(1'b1, mk_instr(8, 17, 7'b0101011, 3'b000), 32'h7FFF_FFFF, 32'd0, "R1", 1'b1, 5'd17, 32'd127);

        // R3: exact limits at N=1 and N=8
        apply(1'b1, mk_instr(1, 9, 7'b0101011, 3'b000), 32'h0000_0005, 32'd0, "R3", 1'b1, 5'd9, 32'd0);
        apply(1'b1, mk_instr(1, 9, 7'b0101011, 3'b000), 32'hFFFF_FFF0, 32'd0, "R3", 1'b1, 5'd9, 32'hFFFF_FFFF);
        apply(1'b1, mk_instr(8, 9, 7'b0101011, 3'b000), 32'h8000_0000, 32'd0, "R3", 1'b1, 5'd9, 32'hFFFF_FF80);

        // R9: valid low drops a legal instruction
        apply(1'b0, mk_instr(8, 5, 7'b0101011, 3'b000), 32'h0000_0010, 32'd1, "R9", 1'b0, 5'd0, 32'd0);

        // R8: reset clears a pending write
        apply(1'b1, mk_instr(16, 4, 7'b0101011, 3'b000), 32'h0000_0100, 32'd4, "R8", 1'b1, 5'd4, 32'h10);
        rst_n = 1'b0;
        apply(1'b1, mk_instr(16, 4, 7'b0101011, 3'b000), 32'h0000_0100, 32'd4, "R8", 1'b0, 5'd0, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule